// File: doc/BRIEF.md
# Load-Tracking Frequency Request Generator

This block lives inside a clock controller. It watches processor activity and decides when the operating point should rise or fall. Sixteen activity lines each carry a 3-bit weight. The weights of the lines that are active in a cycle are added to form a raw load. The raw load, or its value from one cycle earlier, is fed at a slow sample tick into an exponential moving average. The tick comes from a programmable divider of the system clock.

On each tick the smoothed load is compared against three limits: an up limit, a down limit and a panic limit. The up and down decisions are debounced with per-direction repeat counters. A request is raised only when its condition has held for the configured number of consecutive samples. The panic decision acts at once. The result is a 2-bit request code and an interrupt to software. Both are held until software acknowledges them.

The block does not issue a request that the present operating level cannot honour. It also stays quiet while the previous level change is still settling. Typical software settings are: up limit 30, down limit 18, panic limit 63, repeat counts of 51 each, and an average over 32 samples. With these settings, activity lines 11 to 15 carry weight 7 and all other lines carry weight 0.

Top module: `dvfs_load_tracker`

## Requirements
- R1: On a sample tick where the smoothed load is strictly greater than `up_thr_i`, the up counter advances. When it reaches `up_cnt_i` (0 acts as 1), `req_o` becomes 1 (increase) after that clock edge.
- R2: On a sample tick where the smoothed load is strictly less than `dn_thr_i`, the down counter advances. When it reaches `dn_cnt_i` (0 acts as 1), `req_o` becomes 2 (decrease).
- R3: A sample on which a direction's condition fails clears that direction's counter. The next request in that direction then needs the full count again.
- R4: A sample with smoothed load strictly greater than `pnc_thr_i` raises `req_o` = 3 (emergency) at once, without any repeat count. It takes priority over an increase or a decrease.
- R5: `req_o` encodes 0 none, 1 increase, 2 decrease, 3 emergency. A nonzero code holds until `ack_i` is high at a clock edge. That edge clears the request and both counters, and a sample tick on the same edge is discarded.
- R6: At `level_i` = 0 (lowest) no decrease is raised. At `level_i` = 3 (highest) neither an increase nor an emergency is raised. Counters still advance and saturate, so the request follows on the first sample after the level moves.
- R7: While `upd_en_i` is low, no request is raised and both counters keep their values.
- R8: While `en_i` is low, no request is raised, a pending request is dropped, the counters are cleared and the tick divider is held.
- R9: `irq_o` is high exactly when a request is pending and `irq_mask_i` is low.
- R10: The raw load is the sum of `weight_i[3*k+2:3*k]` over every active bit `k` of `act_i`.
- R11: On each tick the average register A (integer part plus 7 fraction bits) becomes A + ((S·2^7 − A) >>> `ema_shift_i`). The comparisons use the integer part of this new value, so the average spans 2^`ema_shift_i` samples.
- R12: With `buf_src_i` = 1 the sample S is the raw load of the tick cycle. With `buf_src_i` = 0 it is the raw load of the cycle before.
- R13: A sample tick occurs once every `div_i`+1 clock cycles. The first tick falls in the cycle in which `div_i` rising edges have passed since reset was released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Tracker enable |
| irq_mask_i | input | 1 | Interrupt mask |
| div_i | input | 16 | Sample tick divider, period `div_i`+1 |
| act_i | input | 16 | Activity lines |
| weight_i | input | 48 | 3-bit weight per activity line |
| buf_src_i | input | 1 | Sample source: 1 current load, 0 previous-cycle load |
| ema_shift_i | input | 3 | log2 of the averaging window |
| up_thr_i | input | 7 | Up limit |
| dn_thr_i | input | 7 | Down limit |
| pnc_thr_i | input | 7 | Panic limit |
| up_cnt_i | input | 8 | Repeat count for increase |
| dn_cnt_i | input | 8 | Repeat count for decrease |
| level_i | input | 2 | Current operating level, 0 lowest, 3 highest |
| upd_en_i | input | 1 | High when a new level change may be requested |
| ack_i | input | 1 | Software acknowledge of the pending request |
| req_o | output | 2 | Pending request code |
| irq_o | output | 1 | Interrupt request |

## Verification
The acknowledge and a sample tick can land on the same clock edge. The acknowledge wants to clear the counters, while the tick wants to advance one of them or raise a new request. With the divider at zero, every cycle is a tick, so the bench drives the acknowledge while the load is still above the up limit or below the down limit. The outcome is judged in two steps. First, `req_o` must drop to 0 on that edge rather than re-arm. Second, the following samples must need the full repeat count again before the next request shows.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;
  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_INC  = 2'd1,
    REQ_DEC  = 2'd2,
    REQ_EMG  = 2'd3
  } req_e;

  localparam logic [1:0] LVL_LOW   = 2'd0;
  localparam logic [1:0] LVL_TURBO = 2'd3;
endpackage

// File: rtl/dvfs_tick_div.sv
module dvfs_tick_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  // >= keeps the period sane if div_i shrinks mid-count
  assign wrap   = (cnt_q >= div_i);
  assign tick_o = en_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (wrap)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dvfs_load_sum.sv
module dvfs_load_sum #(
  parameter int N_ACT  = 16,
  parameter int W_W    = 3,
  parameter int LOAD_W = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_ACT-1:0]     act_i,
  input  logic [N_ACT*W_W-1:0] weight_i,
  input  logic                 buf_src_i,
  output logic [LOAD_W-1:0]    load_o
);
  logic [LOAD_W-1:0] raw;
  logic [LOAD_W-1:0] prev_q;

  always_comb begin
    raw = '0;
    for (int k = 0; k < N_ACT; k++) begin
      if (act_i[k]) raw = raw + LOAD_W'(weight_i[k*W_W +: W_W]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= raw;
  end

  assign load_o = buf_src_i ? raw : prev_q;
endmodule

// File: rtl/dvfs_ema.sv
module dvfs_ema #(
  parameter int LOAD_W = 7,
  parameter int SH_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [LOAD_W-1:0] sample_i,
  input  logic [SH_W-1:0]   shift_i,
  output logic [LOAD_W-1:0] filt_o
);
  localparam int FRAC  = (1 << SH_W) - 1;
  localparam int ACC_W = LOAD_W + FRAC;

  logic        [ACC_W-1:0] acc_q;
  logic        [ACC_W-1:0] target;
  logic        [ACC_W-1:0] acc_nxt;
  logic signed [ACC_W:0]   diff;
  logic signed [ACC_W:0]   step;
  logic signed [ACC_W:0]   sum;

  always_comb begin
    target  = {sample_i, {FRAC{1'b0}}};
    diff    = $signed({1'b0, target}) - $signed({1'b0, acc_q});
    step    = diff >>> shift_i;
    sum     = $signed({1'b0, acc_q}) + step;
    acc_nxt = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (tick_i) acc_q <= acc_nxt;
  end

  // decision sees the value being written on this tick
  assign filt_o = acc_nxt[ACC_W-1:FRAC];
endmodule

// File: rtl/dvfs_decide.sv
module dvfs_decide
  import dvfs_pkg::*;
#(
  parameter int LOAD_W = 7,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic [LOAD_W-1:0] filt_i,
  input  logic [LOAD_W-1:0] up_thr_i,
  input  logic [LOAD_W-1:0] dn_thr_i,
  input  logic [LOAD_W-1:0] pnc_thr_i,
  input  logic [CNT_W-1:0]  up_cnt_i,
  input  logic [CNT_W-1:0]  dn_cnt_i,
  input  logic [1:0]        level_i,
  input  logic              upd_en_i,
  input  logic              ack_i,
  output logic [1:0]        req_o
);
  req_e             req_q, req_n;
  logic [CNT_W-1:0] up_q, up_n, dn_q, dn_n;
  logic [CNT_W-1:0] up_inc, dn_inc;
  logic             over_up, under_dn, panic, at_top, at_low, pend;

  always_comb begin
    over_up  = filt_i > up_thr_i;
    under_dn = filt_i < dn_thr_i;
    panic    = filt_i > pnc_thr_i;
    at_top   = level_i == LVL_TURBO;
    at_low   = level_i == LVL_LOW;
    pend     = req_q != REQ_NONE;
    up_inc   = (&up_q) ? up_q : up_q + 1'b1;
    dn_inc   = (&dn_q) ? dn_q : dn_q + 1'b1;

    req_n = req_q;
    up_n  = up_q;
    dn_n  = dn_q;
    if (!en_i || ack_i) begin
      req_n = REQ_NONE;
      up_n  = '0;
      dn_n  = '0;
    end else if (tick_i && !pend && upd_en_i) begin
      up_n = over_up  ? up_inc : '0;
      dn_n = under_dn ? dn_inc : '0;
      if (panic && !at_top)                              req_n = REQ_EMG;
      else if (over_up && up_inc >= up_cnt_i && !at_top) req_n = REQ_INC;
      else if (under_dn && dn_inc >= dn_cnt_i && !at_low) req_n = REQ_DEC;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= REQ_NONE;
      up_q  <= '0;
      dn_q  <= '0;
    end else begin
      req_q <= req_n;
      up_q  <= up_n;
      dn_q  <= dn_n;
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/dvfs_load_tracker.sv
module dvfs_load_tracker #(
  parameter  int N_ACT  = 16,
  parameter  int W_W    = 3,
  parameter  int CNT_W  = 8,
  parameter  int DIV_W  = 16,
  parameter  int SH_W   = 3,
  localparam int LOAD_W = $clog2(N_ACT * ((1 << W_W) - 1) + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 irq_mask_i,
  input  logic [DIV_W-1:0]     div_i,
  input  logic [N_ACT-1:0]     act_i,
  input  logic [N_ACT*W_W-1:0] weight_i,
  input  logic                 buf_src_i,
  input  logic [SH_W-1:0]      ema_shift_i,
  input  logic [LOAD_W-1:0]    up_thr_i,
  input  logic [LOAD_W-1:0]    dn_thr_i,
  input  logic [LOAD_W-1:0]    pnc_thr_i,
  input  logic [CNT_W-1:0]     up_cnt_i,
  input  logic [CNT_W-1:0]     dn_cnt_i,
  input  logic [1:0]           level_i,
  input  logic                 upd_en_i,
  input  logic                 ack_i,
  output logic [1:0]           req_o,
  output logic                 irq_o
);
  logic              tick_w;
  logic [LOAD_W-1:0] load_w;
  logic [LOAD_W-1:0] filt_w;

  dvfs_tick_div #(.DIV_W(DIV_W)) i_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .div_i (div_i),
    .tick_o(tick_w)
  );

  dvfs_load_sum #(.N_ACT(N_ACT), .W_W(W_W), .LOAD_W(LOAD_W)) i_sum (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .act_i    (act_i),
    .weight_i (weight_i),
    .buf_src_i(buf_src_i),
    .load_o   (load_w)
  );

  dvfs_ema #(.LOAD_W(LOAD_W), .SH_W(SH_W)) i_ema (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_w),
    .sample_i(load_w),
    .shift_i (ema_shift_i),
    .filt_o  (filt_w)
  );

  dvfs_decide #(.LOAD_W(LOAD_W), .CNT_W(CNT_W)) i_decide (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .tick_i   (tick_w),
    .filt_i   (filt_w),
    .up_thr_i (up_thr_i),
    .dn_thr_i (dn_thr_i),
    .pnc_thr_i(pnc_thr_i),
    .up_cnt_i (up_cnt_i),
    .dn_cnt_i (dn_cnt_i),
    .level_i  (level_i),
    .upd_en_i (upd_en_i),
    .ack_i    (ack_i),
    .req_o    (req_o)
  );

  assign irq_o = (req_o != 2'd0) && !irq_mask_i;
endmodule

// File: rtl/dvfs_tracker_chk.sv
module dvfs_tracker_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       irq_mask_i,
  input logic [1:0] level_i,
  input logic       upd_en_i,
  input logic       ack_i,
  input logic       tick_i,
  input logic [1:0] req_o,
  input logic       irq_o
);
  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o != 2'd0 && !ack_i && en_i) |=> $stable(req_o));

  assert_ack_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> (req_o == 2'd0));

  assert_no_dec_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o == 2'd0 && level_i == 2'd0) |=> (req_o != 2'd2));

  assert_no_up_turbo_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o == 2'd0 && level_i == 2'd3) |=> (req_o != 2'd1 && req_o != 2'd3));

  assert_upd_block_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o == 2'd0 && !upd_en_i) |=> (req_o == 2'd0));

  assert_disabled_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (req_o == 2'd0));

  assert_masked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_mask_i |-> !irq_o);

  assert_irq_on_pend_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_mask_i && req_o != 2'd0) |-> irq_o);

  assert_tick_only_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o == 2'd0 && !tick_i) |=> (req_o == 2'd0));
endmodule

bind dvfs_load_tracker dvfs_tracker_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .irq_mask_i(irq_mask_i),
  .level_i   (level_i),
  .upd_en_i  (upd_en_i),
  .ack_i     (ack_i),
  .tick_i    (tick_w),
  .req_o     (req_o),
  .irq_o     (irq_o)
);

// File: tb/test_dvfs_load_tracker.sv
module test_dvfs_load_tracker;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] A_LOW  = 16'h0000; // load 0
  localparam logic [15:0] A_MID  = 16'h3800; // load 21
  localparam logic [15:0] A_HIGH = 16'hF800; // load 35
  localparam logic [47:0] W_DEF  = {5{3'd7}} << 33;
  localparam int NVEC = 23;
  // {act, level, upd_en, ack, expected req}
  localparam logic [21:0] VEC [NVEC] = '{
    {A_MID,  2'd1, 1'b1, 1'b0, 2'd0},
    {A_HIGH, 2'd1, 1'b1, 1'b0, 2'd0},
    {A_HIGH, 2'd1, 1'b1, 1'b0, 2'd0},
    {A_MID,  2'd1, 1'b1, 1'b0, 2'd0}, // R3 clear
    {A_HIGH, 2'd1, 1'b1, 1'b0, 2'd0},
    {A_HIGH, 2'd1, 1'b1, 1'b0, 2'd0},
    {A_HIGH, 2'd1, 1'b1, 1'b0, 2'd1}, // R1
    {A_HIGH, 2'd1, 1'b1, 1'b0, 2'd1}, // R5 hold
    {A_HIGH, 2'd1, 1'b1, 1'b1, 2'd0}, // R5 ack with tick
    {A_LOW,  2'd1, 1'b1, 1'b0, 2'd0},
    {A_LOW,  2'd1, 1'b1, 1'b0, 2'd2}, // R2
    {A_LOW,  2'd1, 1'b1, 1'b1, 2'd0},
    {A_LOW,  2'd0, 1'b1, 1'b0, 2'd0},
    {A_LOW,  2'd0, 1'b1, 1'b0, 2'd0}, // R6 lowest
    {A_LOW,  2'd0, 1'b1, 1'b0, 2'd0},
    {A_LOW,  2'd1, 1'b1, 1'b0, 2'd2}, // R6 saturated count
    {A_LOW,  2'd1, 1'b1, 1'b1, 2'd0},
    {A_HIGH, 2'd3, 1'b1, 1'b0, 2'd0},
    {A_HIGH, 2'd3, 1'b1, 1'b0, 2'd0},
    {A_HIGH, 2'd3, 1'b1, 1'b0, 2'd0}, // R6 turbo
    {A_HIGH, 2'd2, 1'b0, 1'b0, 2'd0}, // R7
    {A_HIGH, 2'd2, 1'b1, 1'b0, 2'd1},
    {A_MID,  2'd2, 1'b1, 1'b1, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b1, irq_mask = 1'b0, buf_src = 1'b1, upd_en = 1'b1, ack = 1'b0;
  logic [15:0] div = '0;
  logic [15:0] act = '0;
  logic [47:0] weight = W_DEF;
  logic [2:0]  ema_shift = '0;
  logic [6:0]  up_thr = 7'd30, dn_thr = 7'd18, pnc_thr = 7'd63;
  logic [7:0]  up_cnt = 8'd3, dn_cnt = 8'd2;
  logic [1:0]  level = 2'd1;
  logic [1:0]  req;
  logic        irq;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dvfs_load_tracker i_dvfs_load_tracker (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .irq_mask_i(irq_mask), .div_i(div),
    .act_i(act), .weight_i(weight), .buf_src_i(buf_src), .ema_shift_i(ema_shift),
    .up_thr_i(up_thr), .dn_thr_i(dn_thr), .pnc_thr_i(pnc_thr), .up_cnt_i(up_cnt),
    .dn_cnt_i(dn_cnt), .level_i(level), .upd_en_i(upd_en), .ack_i(ack),
    .req_o(req), .irq_o(irq)
  );

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic step(input logic [15:0] a, input logic [1:0] l, input logic u, input logic k);
    @(negedge clk);
    act = a; level = l; upd_en = u; ack = k;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    check("R5 reset req", req, 0);
    check("R9 reset irq", irq, 0);

    // R1 R2 R3 R5 R6 R7 table walk
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][21:6], VEC[i][5:4], VEC[i][3], VEC[i][2]);
      check($sformatf("R1/R2/R3/R5/R6/R7 vec %0d", i), req, VEC[i][1:0]);
    end

    // R9 interrupt and mask
    up_cnt = 8'd1;
    step(A_HIGH, 2'd1, 1'b1, 1'b0);
    check("R9 irq pending", irq, 1);
    @(negedge clk); irq_mask = 1'b1; #1;
    check("R9 irq masked", irq, 0);
    check("R9 req kept under mask", req, 1);
    irq_mask = 1'b0;
    step(A_HIGH, 2'd1, 1'b1, 1'b1);

    // R8 enable
    en = 1'b0;
    step(A_HIGH, 2'd1, 1'b1, 1'b0);
    check("R8 disabled no req", req, 0);
    en = 1'b1;
    step(A_HIGH, 2'd1, 1'b1, 1'b0);
    check("R8 enabled req", req, 1);
    en = 1'b0;
    step(A_HIGH, 2'd1, 1'b1, 1'b0);
    check("R8 pending dropped", req, 0);
    en = 1'b1;
    step(A_MID, 2'd1, 1'b1, 1'b0);
    check("R8 stays clear", req, 0);

    // R4 panic, no repeat count
    up_cnt = 8'd3;
    weight = '1;
    step(16'hFFFF, 2'd1, 1'b1, 1'b0);
    check("R4 emergency", req, 3);
    step(16'hFFFF, 2'd1, 1'b1, 1'b1);
    step(16'hFFFF, 2'd3, 1'b1, 1'b0);
    check("R6 no emergency at turbo", req, 0);
    step(A_LOW, 2'd1, 1'b1, 1'b1);

    // R10 weighted sum, strict comparison
    weight = 48'd5; up_thr = 7'd4; dn_thr = 7'd0; up_cnt = 8'd1;
    step(16'h0001, 2'd1, 1'b1, 1'b0);
    check("R10 weight 5 > 4", req, 1);
    step(16'h0001, 2'd1, 1'b1, 1'b1);
    weight = 48'd4;
    step(16'h0001, 2'd1, 1'b1, 1'b0);
    check("R10 weight 4 not > 4", req, 0);
    step(16'h0002, 2'd1, 1'b1, 1'b0);
    check("R10 zero weight", req, 0);

    // R12 previous-cycle source
    weight = W_DEF; up_thr = 7'd30; dn_thr = 7'd18; dn_cnt = 8'd200; buf_src = 1'b0;
    step(A_MID, 2'd1, 1'b1, 1'b0);
    check("R12 mid", req, 0);
    step(A_HIGH, 2'd1, 1'b1, 1'b0);
    check("R12 sees previous mid", req, 0);
    step(A_MID, 2'd1, 1'b1, 1'b0);
    check("R12 sees previous high", req, 1);
    step(A_MID, 2'd1, 1'b1, 1'b1);
    buf_src = 1'b1;

    // R11 average over 2 samples: 17, 26, 30, 32
    act = A_LOW; ema_shift = 3'd1; dn_thr = 7'd0;
    do_reset();
    for (int n = 0; n < 3; n++) begin
      step(A_HIGH, 2'd1, 1'b1, 1'b0);
      check($sformatf("R11 sample %0d below", n), req, 0);
    end
    step(A_HIGH, 2'd1, 1'b1, 1'b0);
    check("R11 fourth sample above", req, 1);

    // R13 divider period 4
    ema_shift = 3'd0; div = 16'd3; act = A_HIGH; ack = 1'b0;
    do_reset();
    for (int n = 0; n < 3; n++) begin
      @(posedge clk); #1;
      check($sformatf("R13 edge %0d no tick", n + 1), req, 0);
    end
    @(posedge clk); #1;
    check("R13 fourth edge tick", req, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule